// File: doc/BRIEF.md
# Platform Interrupt Controller with Claim/Complete

The block collects level-sensitive interrupt requests from a parameterised set of sources and presents them to a small number of processor contexts. Each source passes through a gateway that holds one pending request at a time. Each context has its own enable mask and priority threshold. A context's interrupt line rises whenever at least one pending source that the context has enabled carries a priority strictly above that context's threshold.

Software services a context by reading its claim word. The read returns the identifier of the best eligible source, which is the highest priority, with the lowest identifier winning a tie. In the same access the read clears that source's pending flag and marks it in service. While a source is in service its request line is ignored. Writing the same identifier back to the claim word completes the source, and the gateway may then latch a new request. Source identifier 0 is reserved, so a claim that returns 0 means nothing is eligible. All registers sit on a simple 32-bit bus: a one-cycle request strobe, and a ready pulse with the read data on the following cycle.

Top module: `pirq_ctrl`

## Requirements
- R1: After reset all priorities, enables and thresholds are zero, nothing is pending or in service, every context interrupt is low, and a claim read returns 0.
- R2: The priority of source n (1..NSRC) is the word at byte offset 4*n. It holds PRIO_W bits, and its upper bits read as zero. The word at offset 0 belongs to the reserved source 0: it reads zero and ignores writes.
- R3: The enable mask of context c starts at 0x2000 + 0x80*c. Source n is bit n%32 of word n/32 in that mask. Bit 0 of word 0 reads zero and cannot be set.
- R4: A source whose request input is high, and which is neither pending nor in service, becomes pending at the next clock edge.
- R5: Context c's interrupt is high exactly when some pending source enabled for c has a priority strictly greater than c's threshold. A source with priority 0 never contributes, and a threshold of all ones masks every source.
- R6: A read of context c's claim word returns the eligible source with the highest priority, choosing the lowest identifier among equal priorities, or 0 if no source is eligible.
- R7: A claim clears the returned source's pending flag and marks it in service. While it is in service, that source's request input is ignored.
- R8: Writing the identifier of an in-service source that is enabled for context c to c's claim word ends its service. A request still held high is latched again one cycle later.
- R9: A completion write whose identifier is not in service, or whose source is not enabled for that context, changes nothing.
- R10: bus_rdy is high exactly in the cycle after a cycle with bus_req high, with the read data valid in that cycle. Writes return zero data. Unmapped or misaligned addresses read zero, and writes to them have no effect.
- R11: Context c's control words sit at 0x200000 + 0x1000*c. The threshold is at +0 and holds PRIO_W bits. The claim/complete word is at +4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_irq | input | NSRC | Level requests; bit n is source n (1..NSRC) |
| bus_req | input | 1 | One-cycle access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rdy |
| bus_rdy | output | 1 | Access done, one cycle after bus_req |
| ctx_irq | output | NCTX | Interrupt line per context |

## Verification
Several invariants are checked on every cycle. A source is never pending and in service at once. A source enters service only after a bus read. A raised context line always has some enabled pending source behind it, and a maxed threshold always silences its line. The ready pulse follows each request by exactly one cycle. The arbitration itself can only be shown by the bench's scenarios against its reference model: tie-breaking by lowest identifier, the strict threshold comparison, rejection of bad completions, re-latching after completion, and decoding of unmapped addresses.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
    // address map of the register bus (byte offsets)
    localparam int unsigned EN_BASE    = 32'h0000_2000;
    localparam int unsigned EN_SHIFT   = 7;      // 0x80 bytes per context mask
    localparam int unsigned CTX_BASE   = 32'h0020_0000;
    localparam int unsigned CTX_SHIFT  = 12;     // 0x1000 bytes per context block
    localparam int unsigned OFF_THRESH = 0;
    localparam int unsigned OFF_CLAIM  = 4;
endpackage

// File: rtl/pirq_gate.sv
// One source gateway: holds at most one request, blocks while in service.
module pirq_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic claim_i,
    input  logic done_i,
    output logic pend_o,
    output logic busy_o
);
    typedef struct packed {
        logic pend;
        logic busy;
    } gate_t;

    gate_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (claim_i) begin
            st_d.pend = 1'b0;
            st_d.busy = 1'b1;
        end else begin
            if (done_i) begin
                st_d.busy = 1'b0;
            end
            if (req_i && !st_q.busy && !st_q.pend) begin
                st_d.pend = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_o = st_q.pend;
    assign busy_o = st_q.busy;
endmodule

// File: rtl/pirq_pick.sv
// Per-context winner search: threshold seeds the running best, strict compare
// keeps the lowest identifier on ties.
module pirq_pick #(
    parameter int NSRC   = 31,
    parameter int PRIO_W = 3,
    parameter int ID_W   = 5
) (
    input  logic [NSRC:1]             cand_i,
    input  logic [NSRC:1][PRIO_W-1:0] prio_i,
    input  logic [PRIO_W-1:0]         thr_i,
    output logic [ID_W-1:0]           id_o
);
    logic [PRIO_W-1:0] best;

    always_comb begin
        best = thr_i;
        id_o = '0;
        for (int s = 1; s <= NSRC; s++) begin
            if (cand_i[s] && (prio_i[s] > best)) begin
                best = prio_i[s];
                id_o = ID_W'(s);
            end
        end
    end
endmodule

// File: rtl/pirq_ctrl.sv
module pirq_ctrl #(
    parameter int NSRC   = 31,
    parameter int NCTX   = 2,
    parameter int PRIO_W = 3,
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC:1]     src_irq,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_rdy,
    output logic [NCTX-1:0]   ctx_irq
);
    import pirq_pkg::*;

    localparam int ID_W     = $clog2(NSRC + 1);
    localparam int EN_WORDS = (NSRC + 32) / 32;

    typedef struct packed {
        logic [NSRC:1][PRIO_W-1:0] prio;
        logic [NCTX-1:0][NSRC:1]   en;
        logic [NCTX-1:0][PRIO_W-1:0] thr;
        logic                      rdy;
        logic [31:0]               rdata;
    } regs_t;

    regs_t st_d, st_q;

    logic [NSRC:1]                 pend_w;
    logic [NSRC:1]                 busy_w;
    logic [NSRC:1]                 claim_v;
    logic [NSRC:1]                 done_v;
    logic [NCTX-1:0][ID_W-1:0]     win_id;
    logic [NCTX-1:0][NSRC:1]       en_w;
    logic [NCTX-1:0][PRIO_W-1:0]   thr_w;

    logic              en_hit, ctx_hit;
    logic [ADDR_W-1:0] en_off, ctx_off;

    assign en_w   = st_q.en;
    assign thr_w  = st_q.thr;
    assign en_off  = bus_addr - ADDR_W'(EN_BASE);
    assign ctx_off = bus_addr - ADDR_W'(CTX_BASE);
    assign en_hit  = (bus_addr >= ADDR_W'(EN_BASE)) && (bus_addr[1:0] == 2'b00);
    assign ctx_hit = (bus_addr >= ADDR_W'(CTX_BASE));

    // gateways, one per real source
    for (genvar s = 1; s <= NSRC; s++) begin : g_src
        pirq_gate u_gate (
            .clk     (clk),
            .rst_n   (rst_n),
            .req_i   (src_irq[s]),
            .claim_i (claim_v[s]),
            .done_i  (done_v[s]),
            .pend_o  (pend_w[s]),
            .busy_o  (busy_w[s])
        );
    end

    // winner search, one per context
    for (genvar c = 0; c < NCTX; c++) begin : g_ctx
        pirq_pick #(
            .NSRC   (NSRC),
            .PRIO_W (PRIO_W),
            .ID_W   (ID_W)
        ) u_pick (
            .cand_i (pend_w & en_w[c]),
            .prio_i (st_q.prio),
            .thr_i  (thr_w[c]),
            .id_o   (win_id[c])
        );
        assign ctx_irq[c] = |win_id[c];
    end

    always_comb begin
        st_d       = st_q;
        st_d.rdy   = bus_req;
        st_d.rdata = '0;
        claim_v    = '0;
        done_v     = '0;
        if (bus_req) begin
            // priority words, word aligned
            for (int s = 1; s <= NSRC; s++) begin
                if ((bus_addr[ADDR_W-1:2] == (ADDR_W-2)'(s)) && (bus_addr[1:0] == 2'b00)) begin
                    if (bus_we) begin
                        st_d.prio[s] = bus_wdata[PRIO_W-1:0];
                    end else begin
                        st_d.rdata = 32'(st_q.prio[s]);
                    end
                end
            end
            for (int c = 0; c < NCTX; c++) begin
                // enable mask words
                if (en_hit && (en_off[ADDR_W-1:EN_SHIFT] == (ADDR_W-EN_SHIFT)'(c))) begin
                    for (int w = 0; w < EN_WORDS; w++) begin
                        if (en_off[EN_SHIFT-1:2] == (EN_SHIFT-2)'(w)) begin
                            for (int b = 0; b < 32; b++) begin
                                if ((w * 32 + b >= 1) && (w * 32 + b <= NSRC)) begin
                                    if (bus_we) begin
                                        st_d.en[c][w*32+b] = bus_wdata[b];
                                    end else begin
                                        st_d.rdata[b] = st_q.en[c][w*32+b];
                                    end
                                end
                            end
                        end
                    end
                end
                // threshold and claim/complete
                if (ctx_hit && (ctx_off[ADDR_W-1:CTX_SHIFT] == (ADDR_W-CTX_SHIFT)'(c))) begin
                    if (ctx_off[CTX_SHIFT-1:0] == CTX_SHIFT'(OFF_THRESH)) begin
                        if (bus_we) begin
                            st_d.thr[c] = bus_wdata[PRIO_W-1:0];
                        end else begin
                            st_d.rdata = 32'(st_q.thr[c]);
                        end
                    end else if (ctx_off[CTX_SHIFT-1:0] == CTX_SHIFT'(OFF_CLAIM)) begin
                        if (bus_we) begin
                            for (int s = 1; s <= NSRC; s++) begin
                                if ((bus_wdata == 32'(s)) && busy_w[s] && st_q.en[c][s]) begin
                                    done_v[s] = 1'b1;
                                end
                            end
                        end else begin
                            st_d.rdata = 32'(win_id[c]);
                            for (int s = 1; s <= NSRC; s++) begin
                                if (win_id[c] == ID_W'(s)) begin
                                    claim_v[s] = 1'b1;
                                end
                            end
                        end
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rdy   = st_q.rdy;
    assign bus_rdata = st_q.rdata;
endmodule

// File: rtl/pirq_ctrl_chk.sv
module pirq_ctrl_chk #(
    parameter int NSRC   = 31,
    parameter int NCTX   = 2,
    parameter int PRIO_W = 3
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        bus_req,
    input logic                        bus_we,
    input logic                        bus_rdy,
    input logic [NCTX-1:0]             ctx_irq,
    input logic [NSRC:1]               pend,
    input logic [NSRC:1]               busy,
    input logic [NCTX-1:0][NSRC:1]     en,
    input logic [NCTX-1:0][PRIO_W-1:0] thr
);
    p_rdy_after_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |=> bus_rdy);

    p_no_stray_rdy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_req |=> !bus_rdy);

    p_pend_busy_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pend & busy) == '0);

    p_busy_from_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|(busy & ~$past(busy))) |-> $past(bus_req && !bus_we));

    for (genvar c = 0; c < NCTX; c++) begin : g_chk
        p_irq_has_cand_r5: assert property (@(posedge clk) disable iff (!rst_n)
            ctx_irq[c] |-> (|(pend & en[c])));

        p_max_thr_masks_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (thr[c] == {PRIO_W{1'b1}}) |-> !ctx_irq[c]);
    end
endmodule

bind pirq_ctrl pirq_ctrl_chk #(
    .NSRC   (NSRC),
    .NCTX   (NCTX),
    .PRIO_W (PRIO_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .bus_req (bus_req),
    .bus_we  (bus_we),
    .bus_rdy (bus_rdy),
    .ctx_irq (ctx_irq),
    .pend    (pend_w),
    .busy    (busy_w),
    .en      (en_w),
    .thr     (thr_w)
);

// File: tb/tb_pirq_ctrl.sv
module tb_pirq_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NSRC   = 31;
    localparam int NCTX   = 2;
    localparam int PRIO_W = 3;
    localparam int ADDR_W = 24;
    localparam int PMAX   = (1 << PRIO_W) - 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NSRC:1]     src_irq = '0;
    logic              bus_req = 1'b0;
    logic              bus_we = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              bus_rdy;
    logic [NCTX-1:0]   ctx_irq;

    pirq_ctrl #(.NSRC(NSRC), .NCTX(NCTX), .PRIO_W(PRIO_W), .ADDR_W(ADDR_W)) dut (
        .clk(clk), .rst_n(rst_n), .src_irq(src_irq), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rdy(bus_rdy), .ctx_irq(ctx_irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural reference state
    int m_prio[NSRC+1];
    int m_en[NCTX][NSRC+1];
    int m_thr[NCTX];
    int m_pend[NSRC+1];
    int m_busy[NSRC+1];

    int    vectors = 0;
    int    miscomp = 0;
    int    last_rd = 0;
    bit    done = 1'b0;

    function automatic bit eligible(int c, int s);
        return (m_pend[s] != 0) && (m_en[c][s] != 0) && (m_prio[s] > m_thr[c]);
    endfunction

    function automatic int winner(int c);
        int top = -1;
        for (int s = 1; s <= NSRC; s++)
            if (eligible(c, s) && m_prio[s] > top) top = m_prio[s];
        if (top < 0) return 0;
        for (int s = 1; s <= NSRC; s++)
            if (eligible(c, s) && m_prio[s] == top) return s;
        return 0;
    endfunction

    // 0 unmapped, 1 priority, 2 enable word, 3 threshold, 4 claim
    function automatic int region(int a, output int c, output int idx);
        c = 0; idx = 0;
        if (a % 4 == 0 && a >= 4 && a <= 4 * NSRC) begin
            idx = a / 4; return 1;
        end
        if (a % 4 == 0 && a >= 'h2000 && a < 'h2000 + NCTX * 'h80) begin
            c = (a - 'h2000) / 'h80;
            idx = ((a - 'h2000) % 'h80) / 4;
            if (idx < (NSRC + 32) / 32) return 2;
            return 0;
        end
        if (a >= 'h200000 && a < 'h200000 + NCTX * 'h1000) begin
            c = (a - 'h200000) / 'h1000;
            if ((a - 'h200000) % 'h1000 == 0) return 3;
            if ((a - 'h200000) % 'h1000 == 4) return 4;
        end
        return 0;
    endfunction

    task automatic fail(string tag, int act, int exp);
        miscomp++;
        $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    endtask

    task automatic chk(string tag, int act, int exp);
        vectors++;
        if (act != exp) fail(tag, act, exp);
    endtask

    // one clock: reference update at the edge, comparison at the falling edge
    task automatic tick();
        int c, idx, r, cl, dn, exp_rd, d;
        bit exp_rdy;
        string tag;
        @(posedge clk);
        exp_rdy = bus_req; exp_rd = 0; cl = 0; dn = 0; tag = "R10";
        d = int'(bus_wdata);
        if (bus_req) begin
            r = region(int'(bus_addr), c, idx);
            case (r)
                1: begin tag = "R2";
                    if (bus_we) m_prio[idx] = d & PMAX; else exp_rd = m_prio[idx]; end
                2: begin tag = "R3";
                    for (int b = 0; b < 32; b++) begin
                        int s = idx * 32 + b;
                        if (s >= 1 && s <= NSRC) begin
                            if (bus_we) m_en[c][s] = (d >> b) & 1;
                            else exp_rd = exp_rd | (m_en[c][s] << b);
                        end
                    end
                end
                3: begin tag = "R11";
                    if (bus_we) m_thr[c] = d & PMAX; else exp_rd = m_thr[c]; end
                4: begin
                    if (bus_we) begin
                        if (d >= 1 && d <= NSRC && m_busy[d] != 0 && m_en[c][d] != 0) dn = d;
                    end else begin
                        tag = "R6"; cl = winner(c); exp_rd = cl;
                    end
                end
                default: ;
            endcase
        end
        for (int s = 1; s <= NSRC; s++) begin
            if (s == cl) begin m_pend[s] = 0; m_busy[s] = 1; end
            else if (s == dn) m_busy[s] = 0;
            else if (src_irq[s] && m_busy[s] == 0 && m_pend[s] == 0) m_pend[s] = 1;
        end
        @(negedge clk);
        vectors++;
        for (int k = 0; k < NCTX; k++)
            if (int'(ctx_irq[k]) != int'(winner(k) != 0)) fail("R5", int'(ctx_irq[k]), int'(winner(k) != 0));
        if (bus_rdy != exp_rdy) fail("R10", int'(bus_rdy), int'(exp_rdy));
        if (exp_rdy) begin
            last_rd = int'(bus_rdata);
            if (last_rd != exp_rd) fail(tag, last_rd, exp_rd);
        end
    endtask

    task automatic acc(bit we, int a, int d);
        bus_req = 1'b1; bus_we = we; bus_addr = a[ADDR_W-1:0]; bus_wdata = d;
        tick();
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic wr(int a, int d);
        acc(1'b1, a, d);
    endtask

    task automatic rd(int a);
        acc(1'b0, a, 0);
    endtask

    function automatic int pa(int s);  return 4 * s; endfunction
    function automatic int ea(int c);  return 'h2000 + 'h80 * c; endfunction
    function automatic int ta(int c);  return 'h200000 + 'h1000 * c; endfunction
    function automatic int ca(int c);  return 'h200000 + 'h1000 * c + 4; endfunction

    initial begin
        for (int s = 0; s <= NSRC; s++) begin
            m_prio[s] = 0; m_pend[s] = 0; m_busy[s] = 0;
            for (int c = 0; c < NCTX; c++) m_en[c][s] = 0;
        end
        for (int c = 0; c < NCTX; c++) m_thr[c] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1", int'(ctx_irq), 0);
        rd(ca(0)); chk("R1", last_rd, 0);

        // R2 priority words
        wr(pa(3), 5); wr(pa(7), 5); wr(pa(9), 2); wr(pa(20), 'hFF);
        rd(pa(20)); chk("R2", last_rd, 7);
        wr(0, 7); rd(0); chk("R2", last_rd, 0);
        rd(pa(3)); chk("R2", last_rd, 5);

        // R3 enable words
        wr(ea(0), 32'hFFFF_FFFF); rd(ea(0)); chk("R3", last_rd, 32'hFFFF_FFFE);
        wr(ea(1), 'h280); rd(ea(1)); chk("R3", last_rd, 'h280);

        // R4 latching of requests
        src_irq[3] = 1'b1; src_irq[7] = 1'b1; src_irq[9] = 1'b1;
        tick(); chk("R4", int'(ctx_irq), 3);

        // R5 / R11 threshold
        wr(ta(0), 7); chk("R5", int'(ctx_irq[0]), 0);
        rd(ta(0)); chk("R11", last_rd, 7);
        wr(ta(0), 5); chk("R5", int'(ctx_irq[0]), 0);
        wr(ta(0), 4); chk("R5", int'(ctx_irq[0]), 1);

        // R6 / R7 claims, tie goes to lowest identifier
        rd(ca(0)); chk("R6", last_rd, 3);
        rd(ca(0)); chk("R6", last_rd, 7);
        rd(ca(0)); chk("R6", last_rd, 0);
        chk("R7", int'(ctx_irq[0]), 0);
        chk("R6", int'(ctx_irq[1]), 1);
        rd(ca(1)); chk("R6", last_rd, 9);
        rd(ca(1)); chk("R7", last_rd, 0);

        // R9 rejected completions
        wr(ca(1), 3); wr(ca(0), 5); tick(); tick();
        rd(ca(0)); chk("R9", last_rd, 0);

        // R8 completion re-arms
        wr(ca(0), 3); tick();
        rd(ca(0)); chk("R8", last_rd, 3);

        // R5 priority zero never fires
        wr(ta(0), 0); src_irq[12] = 1'b1; tick();
        rd(ca(0)); chk("R5", last_rd, 0);
        wr(pa(12), 1); rd(ca(0)); chk("R6", last_rd, 12);

        // R10 unmapped and misaligned
        rd('h1000); chk("R10", last_rd, 0);
        rd('h2004); chk("R10", last_rd, 0);
        rd('h2100); chk("R10", last_rd, 0);
        rd('h200008); chk("R10", last_rd, 0);
        wr(pa(3) + 2, 7); rd(pa(3)); chk("R10", last_rd, 5);
        wr('h202000, 7); tick();

        // R8 completion on the second context
        wr(ca(1), 7); tick(); chk("R8", int'(ctx_irq[1]), 1);

        tick();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            miscomp++;
            $display("FAIL watchdog: actual 0x0 expected 0x1 (run did not finish)");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
            $finish;
        end
    end
endmodule